// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block holds the eight 32-bit program registers of a small single-cycle processor core. It has two independent read ports and two independent write ports. One write port carries a computed (arithmetic or address) result. The other carries a value loaded from memory. With both ports, a single instruction can, for example, bump the stack pointer and store a popped word in the same clock cycle.

Every port is steered by a 4-bit register ID. IDs 0 through 7 select a register, in the fixed order eax, ecx, edx, ebx, esp, ebp, esi, edi. ID 8, and every ID above it, means "no register", and the port does nothing.

Reads are purely combinational from the stored state, so a read port follows its ID within the same cycle. Writes land on the rising clock edge. A synchronous active-high reset zeroes the whole file.

Top module: `dual_wr_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, all eight registers become zero. After reset, every read of IDs 0 to 7 returns 0 until a write occurs.
- R2: A read port given ID k in 0..7 drives the current content of register k in the same cycle, with no clock edge in between. A write port given ID k in 0..7 stores its data into register k at the next rising edge.
- R3: A read port given any ID from 8 to 15 drives all zeros.
- R4: A write port given any ID from 8 to 15 changes no register.
- R5: A read of a register that is being written in the same cycle returns the value held before the edge. The new value appears only after the edge.
- R6: When the two write ports name different registers in the same cycle, both registers are updated at that edge.
- R7: When both write ports name the same register in the same cycle, the load port's data is stored and the calc port's data is dropped.
- R8: The two read ports are fully independent. Both may address the same register or different registers in the same cycle.
- R9: Reset takes priority over any write presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset of all registers |
| rd0_id | input | 4 | Register ID of read port 0 (8..15 = idle) |
| rd0_data | output | 32 | Combinational read data of port 0 |
| rd1_id | input | 4 | Register ID of read port 1 (8..15 = idle) |
| rd1_data | output | 32 | Combinational read data of port 1 |
| wr_calc_id | input | 4 | Register ID of the computed-value write port (8..15 = idle) |
| wr_calc_data | input | 32 | Data for the computed-value write port |
| wr_load_id | input | 4 | Register ID of the loaded-value write port (8..15 = idle) |
| wr_load_data | input | 32 | Data for the loaded-value write port; wins on a clash |

## Verification
The assertions take for granted that every input is a known value at each rising edge and that reset is held for at least one edge before the first check. The stored contents are visible only through the read ports, so the write and hold properties compare a read port's value against write-port activity one edge earlier. The stimulus drives all inputs half a cycle away from the active edge, asserts reset first, and draws IDs over the full 4-bit range. About a quarter of the draws fall in the idle range, and a share of cycles has both write ports aimed at one register, so the clash and idle paths are reached often.

// File: rtl/regf_pkg.sv
package regf_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_ID_W   = 4;
  localparam int unsigned DEF_NREGS  = 8;

  // An ID is live when it names a real register; everything at or above
  // the register count is treated as "no register".
  function automatic logic id_is_live(input int unsigned id, input int unsigned nregs);
    return id < nregs;
  endfunction

  // Slot k matches when the ID is live and equals k.
  function automatic logic id_hits_slot(input int unsigned id, input int unsigned slot,
                                        input int unsigned nregs);
    return id_is_live(id, nregs) && (id == slot);
  endfunction
endpackage

// File: rtl/regf_id_decode.sv
module regf_id_decode #(
  parameter int unsigned ID_W  = regf_pkg::DEF_ID_W,
  parameter int unsigned NREGS = regf_pkg::DEF_NREGS
) (
  input  logic [ID_W-1:0]  id,
  output logic             live,
  output logic [NREGS-1:0] onehot
);
  assign live = regf_pkg::id_is_live(int'(id), NREGS);

  for (genvar k = 0; k < NREGS; k++) begin : g_slot
    assign onehot[k] = regf_pkg::id_hits_slot(int'(id), k, NREGS);
  end
endmodule

// File: rtl/regf_read_mux.sv
module regf_read_mux #(
  parameter int unsigned DATA_W = regf_pkg::DEF_DATA_W,
  parameter int unsigned ID_W   = regf_pkg::DEF_ID_W,
  parameter int unsigned NREGS  = regf_pkg::DEF_NREGS
) (
  input  logic [NREGS*DATA_W-1:0] bank_q,
  input  logic [ID_W-1:0]         id,
  output logic [DATA_W-1:0]       data
);
  logic             live;
  logic [NREGS-1:0] sel;

  regf_id_decode #(.ID_W(ID_W), .NREGS(NREGS)) u_dec (
    .id(id), .live(live), .onehot(sel)
  );

  // AND-OR selection: an idle ID selects nothing, so the result is zero.
  logic [DATA_W-1:0] term [NREGS];
  for (genvar k = 0; k < NREGS; k++) begin : g_term
    assign term[k] = bank_q[k*DATA_W +: DATA_W] & {DATA_W{sel[k]}};
  end

  always_comb begin
    data = '0;
    for (int k = 0; k < NREGS; k++) data = data | term[k];
  end

  logic unused_live;
  assign unused_live = live;
endmodule

// File: rtl/regf_bank.sv
module regf_bank #(
  parameter int unsigned DATA_W = regf_pkg::DEF_DATA_W,
  parameter int unsigned NREGS  = regf_pkg::DEF_NREGS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREGS-1:0]        calc_sel,
  input  logic [DATA_W-1:0]       calc_data,
  input  logic [NREGS-1:0]        load_sel,
  input  logic [DATA_W-1:0]       load_data,
  output logic [NREGS*DATA_W-1:0] bank_q
);
  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)              q <= '0;
      else if (load_sel[k]) q <= load_data;
      else if (calc_sel[k]) q <= calc_data;
    end
    assign bank_q[k*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile #(
  parameter int unsigned DATA_W = regf_pkg::DEF_DATA_W,
  parameter int unsigned ID_W   = regf_pkg::DEF_ID_W,
  parameter int unsigned NREGS  = regf_pkg::DEF_NREGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   rd0_id,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ID_W-1:0]   rd1_id,
  output logic [DATA_W-1:0] rd1_data,
  input  logic [ID_W-1:0]   wr_calc_id,
  input  logic [DATA_W-1:0] wr_calc_data,
  input  logic [ID_W-1:0]   wr_load_id,
  input  logic [DATA_W-1:0] wr_load_data
);
  localparam int unsigned BANK_W = NREGS * DATA_W;

  logic             calc_en, load_en, wr_clash;
  logic [NREGS-1:0] calc_sel, load_sel;
  logic [BANK_W-1:0] bank_q;

  regf_id_decode #(.ID_W(ID_W), .NREGS(NREGS)) u_calc_dec (
    .id(wr_calc_id), .live(calc_en), .onehot(calc_sel)
  );
  regf_id_decode #(.ID_W(ID_W), .NREGS(NREGS)) u_load_dec (
    .id(wr_load_id), .live(load_en), .onehot(load_sel)
  );

  // Both write ports hit the same register this cycle.
  assign wr_clash = |(calc_sel & load_sel);

  regf_bank #(.DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
    .clk(clk), .rst(rst),
    .calc_sel(calc_sel), .calc_data(wr_calc_data),
    .load_sel(load_sel), .load_data(wr_load_data),
    .bank_q(bank_q)
  );

  regf_read_mux #(.DATA_W(DATA_W), .ID_W(ID_W), .NREGS(NREGS)) u_rd0 (
    .bank_q(bank_q), .id(rd0_id), .data(rd0_data)
  );
  regf_read_mux #(.DATA_W(DATA_W), .ID_W(ID_W), .NREGS(NREGS)) u_rd1 (
    .bank_q(bank_q), .id(rd1_id), .data(rd1_data)
  );
endmodule

// File: rtl/dual_wr_regfile_chk.sv
module dual_wr_regfile_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned NREGS  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ID_W-1:0]   rd0_id,
  input logic [DATA_W-1:0] rd0_data,
  input logic [ID_W-1:0]   rd1_id,
  input logic [DATA_W-1:0] rd1_data,
  input logic [ID_W-1:0]   wr_calc_id,
  input logic [DATA_W-1:0] wr_calc_data,
  input logic [ID_W-1:0]   wr_load_id,
  input logic [DATA_W-1:0] wr_load_data,
  input logic              calc_en,
  input logic              load_en,
  input logic              wr_clash
);
  // R1 / R9: the cycle after reset every read port shows zero.
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd0_data == '0) && (rd1_data == '0));

  // R3: idle read IDs drive zero.
  assert_idle_read_R3: assert property (@(posedge clk) disable iff (rst)
    (int'(rd0_id) >= NREGS) |-> (rd0_data == '0));
  assert_idle_read1_R3: assert property (@(posedge clk) disable iff (rst)
    (int'(rd1_id) >= NREGS) |-> (rd1_data == '0));

  // R7: on a clash, the load data is what lands.
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(load_en) && (rd0_id == $past(wr_load_id))
    |-> rd0_data == $past(wr_load_data));

  // R2 / R6: the calc write lands when it is not overridden.
  assert_calc_write_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(calc_en) && !$past(wr_clash) && (rd1_id == $past(wr_calc_id))
    |-> rd1_data == $past(wr_calc_data));

  // R4 / R5: a register not written at the last edge keeps its value.
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $stable(rd0_id)
    && !($past(calc_en) && ($past(wr_calc_id) == rd0_id))
    && !($past(load_en) && ($past(wr_load_id) == rd0_id))
    |-> $stable(rd0_data));

  // R8: both ports on the same ID agree.
  assert_ports_agree_R8: assert property (@(posedge clk) disable iff (rst)
    (rd0_id == rd1_id) |-> (rd0_data == rd1_data));
endmodule

bind dual_wr_regfile dual_wr_regfile_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .NREGS(NREGS)) u_chk (
  .clk(clk), .rst(rst),
  .rd0_id(rd0_id), .rd0_data(rd0_data), .rd1_id(rd1_id), .rd1_data(rd1_data),
  .wr_calc_id(wr_calc_id), .wr_calc_data(wr_calc_data),
  .wr_load_id(wr_load_id), .wr_load_data(wr_load_data),
  .calc_en(calc_en), .load_en(load_en), .wr_clash(wr_clash)
);

// File: tb/sim_dual_wr_regfile.sv
`timescale 1ns/1ps
module sim_dual_wr_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd0_id, rd1_id, wr_calc_id, wr_load_id;
  logic [31:0] rd0_data, rd1_data, wr_calc_data, wr_load_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m [8];

  always #4 clk = ~clk;

  dual_wr_regfile u0 (
    .clk(clk), .rst(rst),
    .rd0_id(rd0_id), .rd0_data(rd0_data), .rd1_id(rd1_id), .rd1_data(rd1_data),
    .wr_calc_id(wr_calc_id), .wr_calc_data(wr_calc_data),
    .wr_load_id(wr_load_id), .wr_load_data(wr_load_data)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] id);
    return (id < 4'd8) ? m[id[2:0]] : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One cycle: drive at falling edge, check reads, then model the rising edge.
  task automatic cyc(input logic r, input logic [3:0] a, input logic [3:0] b,
                     input logic [3:0] ci, input logic [31:0] cd,
                     input logic [3:0] li, input logic [31:0] ld, input string req);
    @(negedge clk);
    rst = r; rd0_id = a; rd1_id = b;
    wr_calc_id = ci; wr_calc_data = cd; wr_load_id = li; wr_load_data = ld;
    #1;
    if (!r) begin
      chk(req, rd0_data, exp_read(a));
      chk(req, rd1_data, exp_read(b));
    end
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < 8; k++) m[k] = 32'h0;
    end else begin
      if (ci < 4'd8) m[ci[2:0]] = cd;
      if (li < 4'd8) m[li[2:0]] = ld;
    end
  endtask

  function automatic logic [3:0] rnd_id();
    logic [31:0] r = $urandom;
    return (r[1:0] == 2'd0) ? 4'(8 + r[6:4]) : {1'b0, r[6:4]};
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_2468));
    for (int k = 0; k < 8; k++) m[k] = 32'hx;
    cyc(1'b1, 4'd0, 4'd1, 4'd8, 0, 4'd8, 0, "R1");
    cyc(1'b1, 4'd0, 4'd1, 4'd8, 0, 4'd8, 0, "R1");
    // R1: all registers zero after reset
    for (int k = 0; k < 8; k += 2) cyc(1'b0, 4'(k), 4'(k + 1), 4'd8, 0, 4'd8, 0, "R1");
    // R2: fill every register through alternating ports
    for (int k = 0; k < 8; k++)
      if (k % 2 == 0) cyc(1'b0, 4'd8, 4'd8, 4'(k), 32'hA000_0000 + k, 4'd9, 32'hDEAD, "R2");
      else            cyc(1'b0, 4'd8, 4'd8, 4'd12, 32'hBEEF, 4'(k), 32'hB000_0000 + k, "R2");
    for (int k = 0; k < 8; k += 2) cyc(1'b0, 4'(k), 4'(k + 1), 4'd8, 0, 4'd8, 0, "R2");
    // R8: both ports on one register
    cyc(1'b0, 4'd5, 4'd5, 4'd8, 0, 4'd8, 0, "R8");
    // R4: idle write IDs change nothing
    cyc(1'b0, 4'd8, 4'd15, 4'd8, 32'h1111_1111, 4'd13, 32'h2222_2222, "R4");
    cyc(1'b0, 4'd15, 4'd9, 4'd15, 32'h3333_3333, 4'd9, 32'h4444_4444, "R3");
    for (int k = 0; k < 8; k += 2) cyc(1'b0, 4'(k), 4'(k + 1), 4'd8, 0, 4'd8, 0, "R4");
    // R5: same-cycle read sees old value, then the new one
    cyc(1'b0, 4'd3, 4'd3, 4'd3, 32'h0000_C0DE, 4'd8, 0, "R5");
    cyc(1'b0, 4'd3, 4'd2, 4'd8, 0, 4'd8, 0, "R5");
    // R6: two distinct registers in one edge (stack pointer and popped value)
    cyc(1'b0, 4'd4, 4'd6, 4'd4, 32'h0000_1004, 4'd6, 32'h5A5A_5A5A, "R6");
    cyc(1'b0, 4'd4, 4'd6, 4'd8, 0, 4'd8, 0, "R6");
    // R7: clash, load data wins
    cyc(1'b0, 4'd2, 4'd8, 4'd2, 32'hCA1C_CA1C, 4'd2, 32'h10AD_10AD, "R7");
    cyc(1'b0, 4'd2, 4'd2, 4'd8, 0, 4'd8, 0, "R7");
    // R9: reset beats writes
    cyc(1'b1, 4'd0, 4'd0, 4'd1, 32'hFFFF_FFFF, 4'd7, 32'hEEEE_EEEE, "R9");
    cyc(1'b0, 4'd1, 4'd7, 4'd8, 0, 4'd8, 0, "R9");
    // R2: random traffic across the full ID range
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ci = rnd_id();
      logic [3:0] li = ($urandom % 5 == 0) ? ci : rnd_id();
      cyc(($urandom % 500) == 0, rnd_id(), rnd_id(), ci, $urandom, li, $urandom, "R2");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule